// File: doc/BRIEF.md
# Lock-Aware PLL Post Divider

This block turns a VCO clock into clock-enable pulses for the PLL output clock and for the bus clock. It is a synchronous divider that runs on the VCO clock, so the downstream logic sees enables rather than derived clocks. A 5-bit post-divide field lives in an 8-bit register. While the PLL reports lock, the divide ratio is the field value plus one, so ratios 1 through 32 are available. While the PLL is unlocked, a fixed divide-by-four is used and the field is not consulted.

Software reads the register at any time. A write reaches the field only while the PLL is the selected system clock source; any other write is dropped and the field keeps its value. A change of ratio, whether from a write or from a change of lock, never cuts a period short: the running period finishes at its old length and the new ratio starts with the next period. The bus enable fires on every second PLL enable, which gives a bus rate of half the PLL rate.

Top module: `lapd_top`

## Requirements
- R1: After reset the register reads 0x03 and the PLL enable repeats every 4 VCO cycles.
- R2: The readback carries the field in bits 4:0, and bits 7:5 always read 0. Reads are allowed in any cycle.
- R3: A write with the PLL-select input at 1 loads the field from the write data, visible on the readback in the next cycle.
- R4: A write with the PLL-select input at 0 leaves the field and the divide ratio unchanged.
- R5: With lock at 1, the PLL enable is a one-cycle pulse repeating every (field + 1) VCO cycles, for field values 1 to 31.
- R6: With lock at 1 and a field of 0, the PLL enable is high in every VCO cycle.
- R7: With lock at 0, the PLL enable repeats every 4 VCO cycles whatever the field holds.
- R8: A ratio change made in the middle of a period, through a write or a change of lock, leaves that period at its old length. The new ratio applies from the next period on.
- R9: The bus enable is high only together with the PLL enable and fires on every second PLL enable, so its period is twice the PLL period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | VCO clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lock_i | input | 1 | PLL lock status, 1 when locked |
| pll_sel_i | input | 1 | 1 when the PLL is the selected system clock source |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_field_i | input | 5 | Write data for the post-divide field |
| rd_data_o | output | 8 | Register readback, field in bits 4:0 |
| pll_en_o | output | 1 | PLL clock enable pulse |
| bus_en_o | output | 1 | Bus clock enable pulse |

## Verification
The bench goes after the ratio change in the middle of a period: a design that applied the new ratio at once would produce a runt or stretched period, and the bench measures the period that straddles the change as well as the one after it. It writes with the PLL deselected, where a design without the gate would change both the readback and the measured period. It drives field values of 0 and 31, where an off-by-one in the terminal compare would either stall the enable or lose a cycle, and it drops lock with a large field loaded, where a design that kept using the field would not fall back to four cycles. The bus enable is timed against the PLL enable to catch a toggle that fires on the wrong pulse or a bus pulse that appears between PLL pulses.

// File: rtl/lapd_pkg.sv
// Package: shared definitions for the lock-aware post divider.
// Assumes: consumers pass widths as parameters; only types live here.
package lapd_pkg;

    // Which source decides the ratio of the next divide period.
    typedef enum logic [0:0] {
        RSRC_FIXED = 1'b0,   // PLL not locked: fixed ratio
        RSRC_PROG  = 1'b1    // PLL locked: programmed field + 1
    } ratio_src_e;

endpackage : lapd_pkg

// File: rtl/lapd_cfg_reg.sv
// Module: post-divide configuration register.
// Holds the post-divide field, accepts writes only while the PLL is the
// selected clock source, and presents a zero-padded readback word.
// Assumes: wr_en_i is a single-cycle strobe in the clk domain; reads
// have no side effects.
module lapd_cfg_reg #(
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned RST_VAL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pll_sel_i,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] wr_field_i,
    output logic [FIELD_W-1:0] field_o,
    output logic [REG_W-1:0]   rd_data_o
);

    localparam logic [FIELD_W-1:0] FIELD_RST = FIELD_W'(RST_VAL);

    logic [FIELD_W-1:0] field_q;
    logic               wr_ok;

    // Write gate: only a write with the PLL selected may land.
    always_comb begin
        wr_ok = wr_en_i && pll_sel_i;
    end

    // Field storage: reset value, then gated write updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= FIELD_RST;
        end else if (wr_ok) begin
            field_q <= wr_field_i;
        end
    end

    assign field_o = field_q;

    // Readback: field in the low bits, unimplemented bits forced to zero.
    generate
        if (REG_W > FIELD_W) begin : g_pad
            assign rd_data_o = {{(REG_W - FIELD_W){1'b0}}, field_q};
        end else begin : g_nopad
            assign rd_data_o = field_q[REG_W-1:0];
        end
    endgenerate

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !pll_sel_i) |=> (field_o == $past(field_o))); // R4

    AST_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pll_sel_i) |=> (field_o == $past(wr_field_i))); // R3

    AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(field_o)); // R4

    AST_RD_LOW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[FIELD_W-1:0] == field_o); // R2

endmodule : lapd_cfg_reg

// File: rtl/lapd_ratio_sel.sv
// Module: active ratio selector.
// Picks the ratio for the next divide period from the lock status and the
// programmed field, and holds it stable for a whole period. The ratio is
// only reloaded on a wrap of the divide counter, so no period is cut short.
// Assumes: wrap_i is high for exactly the last cycle of each period.
module lapd_ratio_sel
    import lapd_pkg::*;
#(
    parameter int unsigned FIELD_W     = 5,
    parameter int unsigned FIXED_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               wrap_i,
    output logic [FIELD_W:0]   ratio_o
);

    localparam int unsigned RATIO_W = FIELD_W + 1;
    localparam logic [RATIO_W-1:0] FIXED_R = RATIO_W'(FIXED_RATIO);

    ratio_src_e         src_next;
    logic [RATIO_W-1:0] ratio_next;
    logic [RATIO_W-1:0] ratio_q;

    // Source choice: lock decides between the field and the fixed ratio.
    always_comb begin
        src_next = lock_i ? RSRC_PROG : RSRC_FIXED;
    end

    // Requested ratio for the period that follows the next wrap.
    always_comb begin
        unique case (src_next)
            RSRC_PROG:  ratio_next = {1'b0, field_i} + RATIO_W'(1);
            default:    ratio_next = FIXED_R;
        endcase
    end

    // Active ratio register: reloaded only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= FIXED_R;
        end else if (wrap_i) begin
            ratio_q <= ratio_next;
        end
    end

    assign ratio_o = ratio_q;

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(ratio_o)); // R8

    AST_UNLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !lock_i) |=> (ratio_o == FIXED_R)); // R7

    AST_LOCK_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && lock_i) |=> (ratio_o == {1'b0, $past(field_i)} + RATIO_W'(1))); // R5

    AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_o != '0); // R6

endmodule : lapd_ratio_sel

// File: rtl/lapd_div_core.sv
// Module: divide counter and enable generator.
// Counts VCO cycles up to the active ratio minus one, pulses the PLL enable
// on the last count and restarts at zero. A toggle flop passes every second
// PLL enable through as the bus enable.
// Assumes: ratio_i is at least 1 and changes only in the cycle after a wrap.
module lapd_div_core #(
    parameter int unsigned FIELD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FIELD_W:0] ratio_i,
    output logic             pll_en_o,
    output logic             bus_en_o
);

    localparam int unsigned RATIO_W = FIELD_W + 1;

    logic [FIELD_W-1:0] cnt_q;
    logic               last_cnt;
    logic               half_q;

    // Terminal compare: last cycle of the current period.
    always_comb begin
        last_cnt = ({1'b0, cnt_q} == (ratio_i - RATIO_W'(1)));
    end

    // Period counter: count up, restart at zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (last_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + FIELD_W'(1);
        end
    end

    // Bus phase: flips on each PLL enable so every second one passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (last_cnt) begin
            half_q <= ~half_q;
        end
    end

    assign pll_en_o = last_cnt;
    assign bus_en_o = last_cnt && half_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < ratio_i)); // R5

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |=> (cnt_q == '0)); // R5

    AST_BUS_IN_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> pll_en_o); // R9

    AST_BUS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |=> (!bus_en_o || !pll_en_o || (ratio_i == RATIO_W'(1)) == 1'b0)); // R9

endmodule : lapd_div_core

// File: rtl/lapd_top.sv
// Module: lock-aware PLL post divider, top level.
// Ties the configuration register, the ratio selector and the divide core
// together. All logic runs on the VCO clock; outputs are enables.
// Assumes: lock_i and pll_sel_i are already synchronous to clk_vco.
module lapd_top #(
    parameter int unsigned FIELD_W     = 5,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned RST_FIELD   = 3,
    parameter int unsigned FIXED_RATIO = 4
) (
    input  logic               clk_vco,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic               pll_sel_i,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] wr_field_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               pll_en_o,
    output logic               bus_en_o
);

    logic [FIELD_W-1:0] field;
    logic [FIELD_W:0]   ratio;
    logic               pll_en;

    lapd_cfg_reg #(
        .FIELD_W (FIELD_W),
        .REG_W   (REG_W),
        .RST_VAL (RST_FIELD)
    ) u_cfg (
        .clk        (clk_vco),
        .rst_n      (rst_n),
        .pll_sel_i  (pll_sel_i),
        .wr_en_i    (wr_en_i),
        .wr_field_i (wr_field_i),
        .field_o    (field),
        .rd_data_o  (rd_data_o)
    );

    lapd_ratio_sel #(
        .FIELD_W     (FIELD_W),
        .FIXED_RATIO (FIXED_RATIO)
    ) u_sel (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .lock_i  (lock_i),
        .field_i (field),
        .wrap_i  (pll_en),
        .ratio_o (ratio)
    );

    lapd_div_core #(
        .FIELD_W (FIELD_W)
    ) u_core (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .ratio_i  (ratio),
        .pll_en_o (pll_en),
        .bus_en_o (bus_en_o)
    );

    assign pll_en_o = pll_en;

    AST_UPPER_ZERO: assert property (@(posedge clk_vco) disable iff (!rst_n)
        rd_data_o[REG_W-1:FIELD_W] == '0); // R2

endmodule : lapd_top

// File: tb/lapd_top_test.sv
// Directed bench for the lock-aware post divider. Inputs are driven and
// outputs sampled on the falling edge, away from the active rising edge.
module lapd_top_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk_vco = 1'b0;
    logic       rst_n   = 1'b0;
    logic       lock_i  = 1'b0;
    logic       pll_sel_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [4:0] wr_field_i = '0;
    logic [7:0] rd_data_o;
    logic       pll_en_o;
    logic       bus_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk_vco = ~clk_vco;

    lapd_top uut (
        .clk_vco    (clk_vco),
        .rst_n      (rst_n),
        .lock_i     (lock_i),
        .pll_sel_i  (pll_sel_i),
        .wr_en_i    (wr_en_i),
        .wr_field_i (wr_field_i),
        .rd_data_o  (rd_data_o),
        .pll_en_o   (pll_en_o),
        .bus_en_o   (bus_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge at which the PLL enable is high.
    task automatic wait_pulse();
        do @(negedge clk_vco); while (!pll_en_o);
    endtask

    // Period of the PLL enable in VCO cycles, measured between two pulses.
    task automatic measure_pll(output int p);
        wait_pulse();
        p = 0;
        do begin
            @(negedge clk_vco);
            p++;
        end while (!pll_en_o);
    endtask

    // Write the field with the given select level (driven at a falling edge).
    task automatic do_write(input bit sel, input logic [4:0] val);
        pll_sel_i  = sel;
        wr_en_i    = 1'b1;
        wr_field_i = val;
        @(negedge clk_vco);
        wr_en_i    = 1'b0;
    endtask

    // Let any pending ratio settle by passing two period boundaries.
    task automatic settle();
        wait_pulse();
        wait_pulse();
    endtask

    task automatic t_reset();
        int p;
        check(rd_data_o == 8'h03, "R1 reset readback", rd_data_o, 8'h03);
        measure_pll(p);
        check(p == 4, "R1 period after reset", p, 4);
    endtask

    task automatic t_readback();
        do_write(1'b1, 5'h1F);
        check(rd_data_o == 8'h1F, "R3 write 0x1F", rd_data_o, 8'h1F);
        check(rd_data_o[7:5] == 3'b000, "R2 upper bits zero", rd_data_o[7:5], 0);
        do_write(1'b1, 5'h0A);
        check(rd_data_o == 8'h0A, "R3 write 0x0A", rd_data_o, 8'h0A);
    endtask

    task automatic t_write_blocked();
        int p;
        do_write(1'b0, 5'h11);
        check(rd_data_o == 8'h0A, "R4 blocked write readback", rd_data_o, 8'h0A);
        lock_i = 1'b1;
        settle();
        measure_pll(p);
        check(p == 11, "R4 ratio kept after blocked write", p, 11);
    endtask

    task automatic t_locked_ratios();
        int p;
        do_write(1'b1, 5'd2);
        settle();
        measure_pll(p);
        check(p == 3, "R5 field 2", p, 3);
        do_write(1'b1, 5'd31);
        settle();
        measure_pll(p);
        check(p == 32, "R5 field 31", p, 32);
        do_write(1'b1, 5'd5);
        settle();
        measure_pll(p);
        check(p == 6, "R5 field 5", p, 6);
    endtask

    task automatic t_ratio_one();
        int highs = 0;
        int bus = 0;
        do_write(1'b1, 5'd0);
        settle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_vco);
            if (pll_en_o) highs++;
            if (bus_en_o) bus++;
        end
        check(highs == 6, "R6 enable every cycle", highs, 6);
        check(bus == 3, "R9 bus every second cycle at ratio 1", bus, 3);
    endtask

    task automatic t_unlocked();
        int p;
        do_write(1'b1, 5'd20);
        lock_i = 1'b0;
        settle();
        measure_pll(p);
        check(p == 4, "R7 unlocked fixed ratio", p, 4);
        check(rd_data_o == 8'd20, "R7 field kept while unlocked", rd_data_o, 20);
    endtask

    task automatic t_mid_write();
        int p;
        lock_i = 1'b1;
        do_write(1'b1, 5'd7);
        settle();
        wait_pulse();
        p = 0;
        @(negedge clk_vco);
        p++;
        do_write(1'b1, 5'd1);
        p++;
        while (!pll_en_o) begin
            @(negedge clk_vco);
            p++;
        end
        check(p == 8, "R8 period at write keeps old ratio", p, 8);
        measure_pll(p);
        check(p == 2, "R8 new ratio after wrap", p, 2);
    endtask

    task automatic t_lock_switch();
        int p;
        do_write(1'b1, 5'd7);
        settle();
        wait_pulse();
        p = 0;
        @(negedge clk_vco);
        p++;
        lock_i = 1'b0;
        while (!pll_en_o) begin
            @(negedge clk_vco);
            p++;
        end
        check(p == 8, "R8 lock loss keeps running period", p, 8);
        measure_pll(p);
        check(p == 4, "R8 fixed ratio after lock loss", p, 4);
        lock_i = 1'b1;
        settle();
        measure_pll(p);
        check(p == 8, "R8 programmed ratio after relock", p, 8);
    endtask

    task automatic t_bus();
        int p;
        int stray = 0;
        do_write(1'b1, 5'd2);
        settle();
        do @(negedge clk_vco); while (!bus_en_o);
        p = 0;
        do begin
            @(negedge clk_vco);
            p++;
            if (bus_en_o && !pll_en_o) stray++;
        end while (!bus_en_o);
        check(p == 6, "R9 bus period twice PLL period", p, 6);
        check(stray == 0, "R9 bus only with PLL enable", stray, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_vco);
        rst_n = 1'b1;
        @(negedge clk_vco);
        t_reset();
        t_readback();
        t_write_blocked();
        t_locked_ratios();
        t_ratio_one();
        t_unlocked();
        t_mid_write();
        t_lock_switch();
        t_bus();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule : lapd_top_test